// File: doc/BRIEF.md
# Receive Control Character Extractor

This block sits after an 8B/10B decoder in a serial link receiver. It takes one decoded character per valid cycle: an 8-bit value plus a flag that marks a control (K) character. The transmitter may have added control characters to the stream. This block removes them and turns them into sideband information.

Idle fill characters are dropped. A start-of-cell marker or a command marker is absorbed, and its meaning is attached as a flag to the next character that is produced. A serial address marker makes the following character an address. That address is compared with a configured receiver address and opens or closes an accept switch, which gates all later output. Two edge-signalling characters rebuild a remote interrupt as a level. A reserved control code is reported as a violation.

Output is a registered, valid-qualified character with four flags: start of cell, command, special and violation. The interrupt level is a separate output. Every output follows its input character by one clock.

Top module: `rce_extract`

## Requirements
- R1: After reset `out_valid` is 0, `irq_level` is 0 and the accept switch is on, so the first data character is delivered.
- R2: A data character (`in_is_k`=0) that is accepted appears on `out_data` with `out_valid`=1 one clock after it is presented. On such a character `out_special` and `out_viol` are 0.
- R3: The fill code (K, 0xBC) produces no output and leaves any pending marker unchanged.
- R4: The start-of-cell marker (K, 0xF7) produces no output. The next delivered character carries `out_soc`=1, and the flag is then cleared.
- R5: The command marker (K, 0xFB) produces no output. The next delivered character carries `out_cmd`=1.
- R6: When a second marker arrives before any character has consumed the first, only the newer marker applies.
- R7: The address marker (K, 0xFD) makes the next character an address, and that address is never output. A data character equal to `cfg_addr` turns the accept switch on. Any other character turns it off.
- R8: While the switch is off and `cfg_filter_en`=1, data, special and violation characters are consumed and nothing is output.
- R9: With `cfg_filter_en`=0, characters are delivered whatever the state of the switch.
- R10: The rising-interrupt code (K, 0x1C) sets `irq_level` and the falling-interrupt code (K, 0x7C) clears it, each one clock later. Neither produces output, and both act while the switch is off.
- R11: The violation code (K, 0xFC) is delivered with `out_viol`=1 and `out_special`=0.
- R12: Any other K character is delivered with `out_special`=1, `out_viol`=0 and its code on `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A decoded character is present |
| in_is_k | input | 1 | The character is a control code |
| in_char | input | 8 | Character value |
| cfg_addr | input | 8 | Receiver address that is compared with address characters |
| cfg_filter_en | input | 1 | 1 = the accept switch gates output |
| out_valid | output | 1 | Output character is valid |
| out_data | output | 8 | Output character value |
| out_soc | output | 1 | Character follows a start-of-cell marker |
| out_cmd | output | 1 | Character follows a command marker |
| out_special | output | 1 | Character is a control code that passes through |
| out_viol | output | 1 | Character is the violation code |
| irq_level | output | 1 | Recovered remote interrupt level |

## Verification
The assertions check, on every cycle, these rules:
- A fill code or a marker is never followed by output.
- The interrupt codes move `irq_level` in the following cycle.
- `out_soc` and `out_cmd` are never both set.
- A violation is never also flagged special.
- No data is emitted while the switch is closed and filtering is enabled.

The directed scenarios are needed for rules that span several characters:
- Marker replacement.
- A pending marker that survives a fill code.
- The switch opening and closing across address sequences.
- The effect of turning filtering off.

// File: rtl/rce_pkg.sv
package rce_pkg;

  typedef enum logic [3:0] {
    CL_DATA,
    CL_FILL,
    CL_SOC,
    CL_CMD,
    CL_ADDR,
    CL_IRQ_UP,
    CL_IRQ_DN,
    CL_VIOL,
    CL_SPECIAL
  } char_cls_e;

  typedef enum logic [1:0] {
    PD_NONE,
    PD_SOC,
    PD_CMD,
    PD_ADDR
  } pend_e;

  // marker classes map onto pending kinds
  function automatic pend_e marker_kind(input char_cls_e c);
    case (c)
      CL_SOC:  marker_kind = PD_SOC;
      CL_CMD:  marker_kind = PD_CMD;
      CL_ADDR: marker_kind = PD_ADDR;
      default: marker_kind = PD_NONE;
    endcase
  endfunction

  function automatic logic is_marker(input char_cls_e c);
    is_marker = (c == CL_SOC) || (c == CL_CMD) || (c == CL_ADDR);
  endfunction

  // characters that end a pending marker and may be delivered
  function automatic logic is_payload(input char_cls_e c);
    is_payload = (c == CL_DATA) || (c == CL_VIOL) || (c == CL_SPECIAL);
  endfunction

endpackage

// File: rtl/rce_classify.sv
module rce_classify
  import rce_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter logic [CHAR_W-1:0] CODE_FILL = 8'hBC,
  parameter logic [CHAR_W-1:0] CODE_SOC  = 8'hF7,
  parameter logic [CHAR_W-1:0] CODE_CMD  = 8'hFB,
  parameter logic [CHAR_W-1:0] CODE_ADDR = 8'hFD,
  parameter logic [CHAR_W-1:0] CODE_IRQU = 8'h1C,
  parameter logic [CHAR_W-1:0] CODE_IRQD = 8'h7C,
  parameter logic [CHAR_W-1:0] CODE_VIOL = 8'hFC
) (
  input  logic              is_k,
  input  logic [CHAR_W-1:0] ch,
  output char_cls_e         cls
);

  always_comb begin
    if (!is_k) begin
      cls = CL_DATA;
    end else begin
      case (ch)
        CODE_FILL: cls = CL_FILL;
        CODE_SOC:  cls = CL_SOC;
        CODE_CMD:  cls = CL_CMD;
        CODE_ADDR: cls = CL_ADDR;
        CODE_IRQU: cls = CL_IRQ_UP;
        CODE_IRQD: cls = CL_IRQ_DN;
        CODE_VIOL: cls = CL_VIOL;
        default:   cls = CL_SPECIAL;
      endcase
    end
  end

endmodule

// File: rtl/rce_prefix_state.sv
module rce_prefix_state
  import rce_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ev_marker,
  input  pend_e marker_in,
  input  logic  ev_consume,
  output pend_e pend_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_q <= PD_NONE;
    else if (ev_marker)  pend_q <= marker_in;  // newer marker wins
    else if (ev_consume) pend_q <= PD_NONE;
  end

endmodule

// File: rtl/rce_addr_switch.sv
module rce_addr_switch #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_addr_take,
  input  logic              addr_is_k,
  input  logic [CHAR_W-1:0] addr_char,
  input  logic [CHAR_W-1:0] own_addr,
  output logic              sw_on
);

  function automatic logic addr_hit(input logic k, input logic [CHAR_W-1:0] a,
                                    input logic [CHAR_W-1:0] mine);
    addr_hit = !k && (a == mine);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            sw_on <= 1'b1;
    else if (ev_addr_take) sw_on <= addr_hit(addr_is_k, addr_char, own_addr);
  end

endmodule

// File: rtl/rce_irq_track.sv
module rce_irq_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_up,
  input  logic ev_dn,
  output logic irq_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_q <= 1'b0;
    else if (ev_up) irq_q <= 1'b1;
    else if (ev_dn) irq_q <= 1'b0;
  end

endmodule

// File: rtl/rce_extract.sv
module rce_extract
  import rce_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter logic [CHAR_W-1:0] CODE_FILL = 8'hBC,
  parameter logic [CHAR_W-1:0] CODE_SOC  = 8'hF7,
  parameter logic [CHAR_W-1:0] CODE_CMD  = 8'hFB,
  parameter logic [CHAR_W-1:0] CODE_ADDR = 8'hFD,
  parameter logic [CHAR_W-1:0] CODE_IRQU = 8'h1C,
  parameter logic [CHAR_W-1:0] CODE_IRQD = 8'h7C,
  parameter logic [CHAR_W-1:0] CODE_VIOL = 8'hFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_is_k,
  input  logic [CHAR_W-1:0] in_char,
  input  logic [CHAR_W-1:0] cfg_addr,
  input  logic              cfg_filter_en,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_soc,
  output logic              out_cmd,
  output logic              out_special,
  output logic              out_viol,
  output logic              irq_level
);

  char_cls_e cls;
  pend_e     pend_q;
  logic      sw_on;

  // named internal events
  logic ev_marker, ev_consume, ev_addr_take, ev_emit, ev_irq_up, ev_irq_dn;
  logic gate_open;

  rce_classify #(
    .CHAR_W(CHAR_W), .CODE_FILL(CODE_FILL), .CODE_SOC(CODE_SOC),
    .CODE_CMD(CODE_CMD), .CODE_ADDR(CODE_ADDR), .CODE_IRQU(CODE_IRQU),
    .CODE_IRQD(CODE_IRQD), .CODE_VIOL(CODE_VIOL)
  ) cls_i (
    .is_k(in_is_k), .ch(in_char), .cls(cls)
  );

  always_comb begin
    ev_marker    = in_valid && is_marker(cls);
    ev_consume   = in_valid && is_payload(cls);
    ev_addr_take = ev_consume && (pend_q == PD_ADDR);
    gate_open    = sw_on || !cfg_filter_en;
    ev_emit      = ev_consume && !ev_addr_take && gate_open;
    ev_irq_up    = in_valid && (cls == CL_IRQ_UP);
    ev_irq_dn    = in_valid && (cls == CL_IRQ_DN);
  end

  rce_prefix_state pfx_i (
    .clk(clk), .rst_n(rst_n), .ev_marker(ev_marker),
    .marker_in(marker_kind(cls)), .ev_consume(ev_consume), .pend_q(pend_q)
  );

  rce_addr_switch #(.CHAR_W(CHAR_W)) sw_i (
    .clk(clk), .rst_n(rst_n), .ev_addr_take(ev_addr_take),
    .addr_is_k(in_is_k), .addr_char(in_char), .own_addr(cfg_addr),
    .sw_on(sw_on)
  );

  rce_irq_track irq_i (
    .clk(clk), .rst_n(rst_n), .ev_up(ev_irq_up), .ev_dn(ev_irq_dn),
    .irq_q(irq_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_soc     <= 1'b0;
      out_cmd     <= 1'b0;
      out_special <= 1'b0;
      out_viol    <= 1'b0;
    end else begin
      out_valid <= ev_emit;
      if (ev_emit) begin
        out_data    <= in_char;
        out_soc     <= (pend_q == PD_SOC);
        out_cmd     <= (pend_q == PD_CMD);
        out_special <= (cls == CL_SPECIAL);
        out_viol    <= (cls == CL_VIOL);
      end
    end
  end

endmodule

// File: rtl/rce_extract_chk.sv
module rce_extract_chk #(
  parameter int CHAR_W = 8,
  parameter logic [CHAR_W-1:0] CODE_FILL = 8'hBC,
  parameter logic [CHAR_W-1:0] CODE_SOC  = 8'hF7,
  parameter logic [CHAR_W-1:0] CODE_CMD  = 8'hFB,
  parameter logic [CHAR_W-1:0] CODE_IRQU = 8'h1C,
  parameter logic [CHAR_W-1:0] CODE_IRQD = 8'h7C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_is_k,
  input logic [CHAR_W-1:0] in_char,
  input logic              cfg_filter_en,
  input logic              out_valid,
  input logic              out_soc,
  input logic              out_cmd,
  input logic              out_special,
  input logic              out_viol,
  input logic              irq_level,
  input logic              sw_on,
  input logic              ev_addr_take
);

  assert_fill_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_k && in_char == CODE_FILL) |=> !out_valid);

  assert_soc_absorbed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_k && in_char == CODE_SOC) |=> !out_valid);

  assert_cmd_absorbed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_k && in_char == CODE_CMD) |=> !out_valid);

  assert_one_prefix_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_soc && out_cmd));

  assert_addr_hidden_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_take |=> !out_valid);

  assert_gate_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_filter_en && !sw_on) |=> !out_valid);

  assert_irq_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_k && in_char == CODE_IRQU) |=> (irq_level && !out_valid));

  assert_irq_dn_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_k && in_char == CODE_IRQD) |=> (!irq_level && !out_valid));

  assert_viol_not_special_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_viol && out_special));

  assert_output_needs_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

endmodule

bind rce_extract rce_extract_chk #(
  .CHAR_W(CHAR_W), .CODE_FILL(CODE_FILL), .CODE_SOC(CODE_SOC),
  .CODE_CMD(CODE_CMD), .CODE_IRQU(CODE_IRQU), .CODE_IRQD(CODE_IRQD)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_k(in_is_k),
  .in_char(in_char), .cfg_filter_en(cfg_filter_en), .out_valid(out_valid),
  .out_soc(out_soc), .out_cmd(out_cmd), .out_special(out_special),
  .out_viol(out_viol), .irq_level(irq_level), .sw_on(sw_on),
  .ev_addr_take(ev_addr_take)
);

// File: tb/rce_extract_tb.sv
`timescale 1ns/1ps
module rce_extract_tb_top;

  localparam logic [7:0] K_FILL = 8'hBC, K_SOC = 8'hF7, K_CMD = 8'hFB,
                         K_ADDR = 8'hFD, K_IRQU = 8'h1C, K_IRQD = 8'h7C,
                         K_VIOL = 8'hFC, K_OTHER = 8'h3C, MY_ADDR = 8'h42;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_is_k = 1'b0;
  logic [7:0] in_char = '0;
  logic [7:0] cfg_addr = MY_ADDR;
  logic cfg_filter_en = 1'b1;
  logic out_valid, out_soc, out_cmd, out_special, out_viol, irq_level;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rce_extract dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_k(in_is_k),
    .in_char(in_char), .cfg_addr(cfg_addr), .cfg_filter_en(cfg_filter_en),
    .out_valid(out_valid), .out_data(out_data), .out_soc(out_soc),
    .out_cmd(out_cmd), .out_special(out_special), .out_viol(out_viol),
    .irq_level(irq_level)
  );

  // present one character for one clock; on return the result is visible
  task automatic put(input logic k, input logic [7:0] ch);
    @(negedge clk);
    in_valid = 1'b1; in_is_k = k; in_char = ch;
    @(negedge clk);
    in_valid = 1'b0; in_is_k = 1'b0; in_char = '0;
  endtask

  task automatic chk_none(input string req);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s: out_valid actual %b expected 0", req, out_valid);
    end
  endtask

  // expected: {valid, data, soc, cmd, special, viol}
  task automatic chk_out(input string req, input logic [7:0] d, input logic s,
                         input logic c, input logic sp, input logic v);
    logic [12:0] act, exp;
    act = {out_valid, out_data, out_soc, out_cmd, out_special, out_viol};
    exp = {1'b1, d, s, c, sp, v};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_irq(input string req, input logic e);
    checks++;
    if (irq_level !== e) begin
      errors++;
      $display("FAIL %s: irq_level actual %b expected %b", req, irq_level, e);
    end
  endtask

  task automatic t_reset;
    chk_none("R1");
    chk_irq("R1", 1'b0);
    put(1'b0, 8'h5A); chk_out("R1", 8'h5A, 0, 0, 0, 0);
  endtask

  task automatic t_data;
    put(1'b0, 8'h00); chk_out("R2", 8'h00, 0, 0, 0, 0);
    put(1'b0, 8'hFF); chk_out("R2", 8'hFF, 0, 0, 0, 0);
    put(1'b0, K_SOC); chk_out("R2", K_SOC, 0, 0, 0, 0);  // data value equal to a code
  endtask

  task automatic t_fill;
    put(1'b1, K_FILL); chk_none("R3");
    put(1'b1, K_SOC);  chk_none("R4");
    put(1'b1, K_FILL); chk_none("R3");
    put(1'b0, 8'h21);  chk_out("R3", 8'h21, 1, 0, 0, 0);
  endtask

  task automatic t_soc_cmd;
    put(1'b1, K_SOC); put(1'b0, 8'h10); chk_out("R4", 8'h10, 1, 0, 0, 0);
    put(1'b0, 8'h11); chk_out("R4", 8'h11, 0, 0, 0, 0);
    put(1'b1, K_CMD); chk_none("R5");
    put(1'b0, 8'h99); chk_out("R5", 8'h99, 0, 1, 0, 0);
  endtask

  task automatic t_replace;
    put(1'b1, K_SOC); put(1'b1, K_CMD);
    put(1'b0, 8'h33); chk_out("R6", 8'h33, 0, 1, 0, 0);
    put(1'b1, K_CMD); put(1'b1, K_SOC);
    put(1'b0, 8'h34); chk_out("R6", 8'h34, 1, 0, 0, 0);
  endtask

  task automatic t_kinds;
    put(1'b1, K_OTHER); chk_out("R12", K_OTHER, 0, 0, 1, 0);
    put(1'b1, K_VIOL);  chk_out("R11", K_VIOL, 0, 0, 0, 1);
    put(1'b1, K_SOC); put(1'b1, K_VIOL); chk_out("R11", K_VIOL, 1, 0, 0, 1);
  endtask

  task automatic t_addr;
    put(1'b1, K_ADDR); chk_none("R7");
    put(1'b0, 8'h43);  chk_none("R7");
    put(1'b0, 8'h55);  chk_none("R8");
    put(1'b1, K_OTHER); chk_none("R8");
    put(1'b1, K_VIOL);  chk_none("R8");
    put(1'b1, K_IRQU);  chk_none("R10"); chk_irq("R10", 1'b1);
    cfg_filter_en = 1'b0;
    put(1'b0, 8'h66);  chk_out("R9", 8'h66, 0, 0, 0, 0);
    cfg_filter_en = 1'b1;
    put(1'b0, 8'h67);  chk_none("R8");
    put(1'b1, K_ADDR); put(1'b0, MY_ADDR); chk_none("R7");
    put(1'b0, 8'h77);  chk_out("R7", 8'h77, 0, 0, 0, 0);
    put(1'b1, K_ADDR); put(1'b1, MY_ADDR); chk_none("R7");  // K never matches
    put(1'b0, 8'h78);  chk_none("R7");
    put(1'b1, K_IRQD); chk_irq("R10", 1'b0); chk_none("R10");
    put(1'b1, K_ADDR); put(1'b0, MY_ADDR);
    put(1'b0, 8'h79);  chk_out("R7", 8'h79, 0, 0, 0, 0);
  endtask

  task automatic t_irq;
    put(1'b1, K_IRQU); chk_irq("R10", 1'b1); chk_none("R10");
    put(1'b0, 8'h01);  chk_irq("R10", 1'b1);
    put(1'b1, K_IRQD); chk_irq("R10", 1'b0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data();
    t_fill();
    t_soc_cmd();
    t_replace();
    t_kinds();
    t_addr();
    t_irq();
    finish_run();
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule